// File: doc/BRIEF.md
# UART Transmit Holding and Status Logic

This block sits between a host and the serial output of a UART transmitter. The host writes bytes one at a time. In single-byte mode they land in a one-entry holding register. In buffered mode they land in a first-in first-out store with a depth set by a parameter, 64 by default. A serializer takes the oldest stored byte whenever it has nothing to send. It then drives one 8N1 character on the serial line, advancing one bit position on each pulse of an externally supplied bit-rate tick.

Two status flags report the state of the transmit path. The holding-empty flag shows whether the buffer, in either mode, has room for nothing pending. It reads 1 when the buffer holds no byte. The transmitter-idle flag reads 1 only when the buffer is empty and the serializer is also done, so the host can tell when the last stop bit has left the line. Baud generation, interrupts and register decoding lie outside this block.

Top module: `uart_tx_holdstat`

## Requirements
- R1: While reset is held and on the first cycle after it is released, hold_empty = 1, xmit_idle = 1 and txd = 1.
- R2: A write accepted while hold_empty = 1 makes hold_empty read 0 from the clock edge that captures it.
- R3: In single-byte mode (fifo_mode = 0) the buffer holds one byte. hold_empty returns to 1 at the edge where that byte moves into the serializer. That move happens at the first edge at which the serializer is idle and the byte is present.
- R4: In buffered mode (fifo_mode = 1) the buffer holds up to DEPTH (64) bytes. hold_empty reads 1 exactly when it holds zero bytes.
- R5: xmit_idle reads 1 exactly when the buffer holds no byte and the serializer is not sending a character.
- R6: A character starts with txd = 0 from the edge that loads it. Eight data bits follow, least significant bit first, then a stop bit of 1. Each bit is held until the edge at which bit_tick = 1 is sampled. The character ends at the tick that closes the stop bit. txd is 1 whenever no character is being sent.
- R7: The serializer loads the next byte only after the stop bit of the current character has finished. With bit_tick high every cycle, back-to-back characters occupy 11 clock cycles each.
- R8: A write while the buffer is full is ignored. Full means 1 byte in single-byte mode or DEPTH bytes in buffered mode. Stored bytes are not overwritten, and bytes leave in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_mode | input | 1 | 1 = buffered mode with DEPTH entries, 0 = single-byte holding register |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to transmit |
| bit_tick | input | 1 | One-cycle pulse marking the end of a bit period |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Buffer holds no byte |
| xmit_idle | output | 1 | Buffer empty and serializer finished |

## Verification
The checker assumes that fifo_mode changes only while xmit_idle reads 1. Changing the capacity under a loaded buffer is outside the defined behaviour. It also assumes that bit_tick is a plain per-cycle enable with no minimum spacing. The stimulus sets the mode only after waiting for xmit_idle, and it draws bit_tick both from fixed spacings and from random patterns, including long runs with no tick at all, so that the buffer fills to its limit.

// File: rtl/txh_pkg.sv
// Shared constants and types for the transmit holding/status block.
// Assumes 8N1 framing: one start bit, eight data bits, one stop bit.
package txh_pkg;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_BUSY = 1'b1
    } ser_state_t;
endpackage

// File: rtl/txh_buffer.sv
// Byte buffer that acts as a single holding register (fifo_mode = 0)
// or as a DEPTH-entry first-in first-out store (fifo_mode = 1).
// Assumes pop is asserted only when level is non-zero, and that
// fifo_mode changes only while the buffer is empty.
module txh_buffer #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_FIFO = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_ONE  = CW'(1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] count;
    logic          full;
    logic          accept;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // capacity depends on the mode; writes beyond it are dropped
    always_comb begin
        full   = (count >= (fifo_mode ? CAP_FIFO : CAP_ONE));
        accept = wr_en && !full;
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (accept) wptr <= ptr_next(wptr);
            if (pop)    rptr <= ptr_next(rptr);
            case ({accept, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // storage array, written only on an accepted write
    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wr_data;
    end

    assign rd_data = mem[rptr];
    assign level   = count;
endmodule

// File: rtl/txh_serializer.sv
// Shifts one 8N1 character onto txd, advancing on each bit_tick.
// Takes a new byte only when idle, so a character always completes
// its stop bit before the next start bit. Assumes have_data/data are
// valid in the same cycle.
module txh_serializer
    import txh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 have_data,
    input  logic [DATA_BITS-1:0] data,
    output logic                 take,
    output logic                 busy,
    output logic                 txd
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    ser_state_t              state;
    logic [FRAME_BITS-1:0]   frame;
    logic [CNT_W-1:0]        bit_idx;

    // accept a byte whenever nothing is on the line
    assign take = (state == SER_IDLE) && have_data;

    // load a frame, then shift it out one bit per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SER_IDLE;
            frame   <= '1;
            bit_idx <= '0;
        end else if (take) begin
            state   <= SER_BUSY;
            frame   <= {1'b1, data, 1'b0};
            bit_idx <= '0;
        end else if (state == SER_BUSY && bit_tick) begin
            frame   <= {1'b1, frame[FRAME_BITS-1:1]};
            bit_idx <= bit_idx + CNT_W'(1);
            if (bit_idx == LAST_BIT) state <= SER_IDLE;
        end
    end

    assign busy = (state == SER_BUSY);
    assign txd  = frame[0];
endmodule

// File: rtl/uart_tx_holdstat.sv
// Transmit holding path of a UART: host byte buffer plus serializer,
// with holding-empty and transmitter-idle status. Assumes fifo_mode
// is changed only while xmit_idle is high.
module uart_tx_holdstat #(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_mode,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       bit_tick,
    output logic       txd,
    output logic       hold_empty,
    output logic       xmit_idle
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] buf_level;
    logic [7:0]    buf_head;
    logic          ser_take;
    logic          ser_busy;
    logic          buf_has;

    txh_buffer #(.DEPTH(DEPTH), .W(8)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pop       (ser_take),
        .rd_data   (buf_head),
        .level     (buf_level)
    );

    txh_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .have_data (buf_has),
        .data      (buf_head),
        .take      (ser_take),
        .busy      (ser_busy),
        .txd       (txd)
    );

    // status flags derived from buffer occupancy and serializer activity
    always_comb begin
        buf_has    = (buf_level != '0);
        hold_empty = !buf_has;
        xmit_idle  = !buf_has && !ser_busy;
    end
endmodule

// File: rtl/txh_checker.sv
// Property checker for uart_tx_holdstat, attached by bind.
// Assumes fifo_mode changes only while xmit_idle is high.
module txh_checker #(
    parameter int DEPTH = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fifo_mode,
    input logic                       wr_en,
    input logic                       bit_tick,
    input logic                       txd,
    input logic                       hold_empty,
    input logic                       xmit_idle,
    input logic                       busy,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int CW = $clog2(DEPTH + 1);
    logic at_cap;
    assign at_cap = (level == (fifo_mode ? CW'(DEPTH) : CW'(1)));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (hold_empty && xmit_idle && txd));

    // R2
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_empty) |=> !hold_empty);

    // R5
    idle_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_idle |-> (hold_empty && txd));

    // R5
    line_low_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> !xmit_idle);

    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> $stable(txd));

    // R8
    full_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_cap && wr_en && busy) |=> (level == $past(level)));
endmodule

bind uart_tx_holdstat txh_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_mode  (fifo_mode),
    .wr_en      (wr_en),
    .bit_tick   (bit_tick),
    .txd        (txd),
    .hold_empty (hold_empty),
    .xmit_idle  (xmit_idle),
    .busy       (ser_busy),
    .level      (buf_level)
);

// File: tb/uart_tx_holdstat_bench.sv
`timescale 1ns/1ps
module uart_tx_holdstat_bench;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit_tick = 1'b0;
    logic       txd, hold_empty, xmit_idle;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_tx_holdstat #(.DEPTH(DEPTH)) u_uart_tx_holdstat (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .wr_en(wr_en),
        .wr_data(wr_data), .bit_tick(bit_tick), .txd(txd),
        .hold_empty(hold_empty), .xmit_idle(xmit_idle)
    );

    // behavioural reference: queue of pending bytes plus a frame position
    logic [7:0] q[$];
    bit         m_busy = 1'b0;
    int         m_idx = 0;
    logic [7:0] m_sh = 8'h00;
    always @(posedge clk) begin
        int cap;
        int pre;
        cap = fifo_mode ? DEPTH : 1;
        pre = q.size();
        if (!rst_n) begin
            q.delete();
            m_busy = 1'b0;
            m_idx = 0;
        end else begin
            if (m_busy && bit_tick) begin
                if (m_idx == 9) m_busy = 1'b0;
                else m_idx++;
            end else if (!m_busy && pre > 0) begin
                m_sh = q.pop_front();
                m_busy = 1'b1;
                m_idx = 0;
            end
            if (wr_en && pre < cap) q.push_back(wr_data);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs against the reference
    task automatic compare();
        logic e_txd;
        logic e_empty;
        logic e_idle;
        e_empty = (q.size() == 0);
        e_idle  = e_empty && !m_busy;
        if (!m_busy) e_txd = 1'b1;
        else if (m_idx == 0) e_txd = 1'b0;
        else if (m_idx == 9) e_txd = 1'b1;
        else e_txd = m_sh[m_idx-1];
        check(hold_empty === e_empty, fifo_mode ? "R4 hold_empty" : "R3 hold_empty",
              int'(hold_empty), int'(e_empty));
        check(xmit_idle === e_idle, "R5 xmit_idle", int'(xmit_idle), int'(e_idle));
        check(txd === e_txd, "R6 txd", int'(txd), int'(e_txd));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && !xmit_idle; i++) begin
            bit_tick = 1'b1;
            cyc();
        end
        bit_tick = 1'b0;
    endtask

    // random traffic with a chosen tick spacing and write rate
    task automatic traffic(input int n, input int spacing, input int wr_pct);
        for (int i = 0; i < n; i++) begin
            bit_tick = (spacing == 0) ? 1'($urandom_range(0, 1)) : (i % spacing == 0);
            wr_en    = ($urandom_range(0, 99) < wr_pct);
            wr_data  = 8'($urandom);
            cyc();
        end
        wr_en = 1'b0;
    endtask

    // fill with ticks off, then drain with a tick every cycle and time it
    task automatic overflow_drain(input int writes, input int exp_edges, input string tag);
        int edges;
        bit_tick = 1'b0;
        for (int i = 0; i < writes; i++) begin
            wr_en = 1'b1;
            wr_data = 8'(8'hA0 + i);
            cyc();
        end
        wr_en = 1'b0;
        check(hold_empty == 1'b0, {tag, " buffer loaded"}, int'(hold_empty), 0);
        edges = 0;
        bit_tick = 1'b1;
        while (!xmit_idle && edges < 5000) begin
            cyc();
            edges++;
        end
        bit_tick = 1'b0;
        check(edges == exp_edges, {tag, " drain edges"}, edges, exp_edges);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) cyc();
        // R1 reset state
        check(hold_empty && xmit_idle && txd, "R1 reset flags", {hold_empty, xmit_idle, txd}, 7);
        @(negedge clk);
        rst_n = 1'b1;
        cyc();
        check(hold_empty && xmit_idle && txd, "R1 after release", {hold_empty, xmit_idle, txd}, 7);

        // R2 and R3: single write in holding-register mode
        wr_en = 1'b1; wr_data = 8'h5A;
        cyc();
        wr_en = 1'b0;
        check(hold_empty == 1'b0, "R2 flag clears on write", int'(hold_empty), 0);
        cyc();
        check(hold_empty == 1'b1, "R3 flag sets on transfer", int'(hold_empty), 1);
        check(xmit_idle == 1'b0, "R5 busy while sending", int'(xmit_idle), 0);
        wait_idle();

        // holding mode traffic at several tick spacings
        traffic(1500, 3, 30);
        traffic(1500, 1, 60);
        traffic(1500, 0, 20);
        wait_idle();
        // R8 and R7 in holding mode: 1 sent + 1 held, 3 dropped
        overflow_drain(5, 21, "R8 R7 single");

        // buffered mode
        fifo_mode = 1'b1;
        cyc();
        wr_en = 1'b1; wr_data = 8'h3C;
        cyc();
        wr_en = 1'b0;
        check(hold_empty == 1'b0, "R2 flag clears in buffered mode", int'(hold_empty), 0);
        wait_idle();
        traffic(3000, 11, 15);
        traffic(3000, 2, 50);
        traffic(3000, 0, 40);
        wait_idle();
        // R8 and R7 in buffered mode: 1 sent + 64 held, 6 dropped
        overflow_drain(71, 10 + 11 * DEPTH, "R8 R7 buffered");
        check(hold_empty && xmit_idle, "R4 empty after drain", {hold_empty, xmit_idle}, 3);

        finish_run();
    end
endmodule